// File: doc/BRIEF.md
# Low-Power Mode Clock Sequencer

This block moves a small CPU subsystem between normal running and two low-power modes and brings it back out again. In the light mode the CPU clock is gated off while the peripherals keep their clock. An enabled interrupt or a debug break wakes the subsystem from this mode. In the deep mode both clock enables are dropped. Only an interrupt can start the way back, and the CPU clock returns only after an internal counter has timed out a recovery period. That period is either long (4096 cycles) or short (32 cycles), chosen by a configuration bit.

On every return to running the block issues a one-clock strobe that lets the interrupt stacking sequence begin. A break that ends the light mode leaves a sticky status flag, which software clears by writing 1. A watchdog-enable output follows the inverse of a watchdog-disable configuration bit while the core is running or in the light mode. The asynchronous reset sends the block straight back to running and clears the recovery counter.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: While reset is applied and just after it is released, cpu_clk_en and per_clk_en are 1, stack_go is 0 and bw_flag is 0.
- R2: In run mode, a wait_req with stop_req low enters wait mode at the next clock edge. In wait mode cpu_clk_en is 0 and per_clk_en is 1.
- R3: In wait mode, wake_irq or brk at a clock edge returns the block to run mode at that edge. stack_go is then 1 for exactly the one cycle that follows the exit event.
- R4: A brk that ends wait mode sets bw_flag, and bw_flag stays set until a cycle with bw_clr at 1. If set and clear arrive in the same cycle, set wins. A brk in run mode leaves bw_flag unchanged.
- R5: wdog_en equals the inverse of wdog_dis in run and wait modes, and is 0 in stop mode and during stop recovery.
- R6: In run mode, stop_req enters stop mode at the next edge, and it takes priority over a wait_req in the same cycle. In stop mode both clock enables are 0.
- R7: In stop mode, wake_irq starts recovery with the counter at zero. After exactly 32 cycles (short_rec=1) or 4096 cycles (short_rec=0), counted from the wake edge, the block returns to run mode and pulses stack_go. Both clock enables stay 0 until that point.
- R8: brk has no effect in stop mode or during recovery. It neither wakes the block nor changes bw_flag.
- R9: wait_req and stop_req are ignored in every mode except run mode.
- R10: Asserting rst_n low returns the block to run mode at once, without waiting for a clock edge. The next stop recovery then lasts its full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_req | input | 1 | CPU request to enter wait mode |
| stop_req | input | 1 | CPU request to enter stop mode |
| wake_irq | input | 1 | Enabled interrupt request |
| brk | input | 1 | Debug break request |
| short_rec | input | 1 | 1 selects the 32-cycle stop recovery |
| wdog_dis | input | 1 | Watchdog-disable configuration bit |
| bw_clr | input | 1 | Software write of 1 to the break-wait flag |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| stack_go | output | 1 | One-cycle strobe that releases interrupt stacking |
| bw_flag | output | 1 | Sticky break-wait status |
| wdog_en | output | 1 | Watchdog enable |

## Verification
Two functions can fall in the same cycle. A break that wakes the block from wait mode sets the break-wait flag, and a software clear of that flag can arrive in that same cycle. The bench drives brk and bw_clr together while the block is in wait mode. It then expects the flag to read 1 in the following cycle, alongside the stacking strobe. A clear issued alone one cycle later must then drop the flag to 0.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    LPM_RUN   = 2'd0,
    LPM_WAIT  = 2'd1,
    LPM_STOP  = 2'd2,
    LPM_RECOV = 2'd3
  } lpm_state_e;
endpackage

// File: rtl/lpm_rec_timer.sv
module lpm_rec_timer #(
  parameter int LONG_CYC  = 4096,
  parameter int SHORT_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  input  logic short_sel,
  output logic done
);
  localparam int CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last_val;

  generate
    if (SHORT_CYC >= LONG_CYC) begin : g_single
      assign last_val = LONG_LAST;
    end else begin : g_dual
      assign last_val = short_sel ? SHORT_LAST : LONG_LAST;
    end
  endgenerate

  // counter held at zero whenever recovery is not in progress
  always_comb begin
    if (count_en) cnt_d = cnt_q + 1'b1;
    else          cnt_d = '0;
    done = count_en && (cnt_q == last_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lpm_brk_flag.sv
module lpm_brk_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wait_req,
  input  logic       stop_req,
  input  logic       wake_irq,
  input  logic       brk,
  input  logic       rec_done,
  output lpm_state_e state_q,
  output logic       stack_go_q,
  output logic       brk_wake
);
  lpm_state_e state_d;
  logic       stack_go_d;
  logic       wait_exit;

  always_comb begin
    wait_exit  = (state_q == LPM_WAIT) && (wake_irq || brk);
    brk_wake   = (state_q == LPM_WAIT) && brk;
    stack_go_d = wait_exit || ((state_q == LPM_RECOV) && rec_done);
    state_d    = state_q;
    unique case (state_q)
      LPM_RUN: begin
        if (stop_req)      state_d = LPM_STOP;
        else if (wait_req) state_d = LPM_WAIT;
      end
      LPM_WAIT:  if (wait_exit) state_d = LPM_RUN;
      LPM_STOP:  if (wake_irq)  state_d = LPM_RECOV;
      LPM_RECOV: if (rec_done)  state_d = LPM_RUN;
      default:   state_d = LPM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= LPM_RUN;
      stack_go_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      stack_go_q <= stack_go_d;
    end
  end
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int LONG_CYC  = 4096,
  parameter int SHORT_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_req,
  input  logic stop_req,
  input  logic wake_irq,
  input  logic brk,
  input  logic short_rec,
  input  logic wdog_dis,
  input  logic bw_clr,
  output logic cpu_clk_en,
  output logic per_clk_en,
  output logic stack_go,
  output logic bw_flag,
  output logic wdog_en
);
  lpm_state_e st_q;
  logic       rec_done;
  logic       brk_wake;
  logic       in_recov;

  assign in_recov = (st_q == LPM_RECOV);

  lpm_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wait_req  (wait_req),
    .stop_req  (stop_req),
    .wake_irq  (wake_irq),
    .brk       (brk),
    .rec_done  (rec_done),
    .state_q   (st_q),
    .stack_go_q(stack_go),
    .brk_wake  (brk_wake)
  );

  lpm_rec_timer #(
    .LONG_CYC (LONG_CYC),
    .SHORT_CYC(SHORT_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (in_recov),
    .short_sel(short_rec),
    .done     (rec_done)
  );

  lpm_brk_flag u_bwflag (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (brk_wake),
    .clr_i (bw_clr),
    .flag_q(bw_flag)
  );

  always_comb begin
    cpu_clk_en = (st_q == LPM_RUN);
    per_clk_en = (st_q == LPM_RUN) || (st_q == LPM_WAIT);
    wdog_en    = !wdog_dis && per_clk_en;
  end
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic wait_req,
  input logic stop_req,
  input logic brk,
  input logic cpu_clk_en,
  input logic per_clk_en,
  input logic stack_go,
  input logic bw_flag,
  input logic wdog_en
);
  // R2
  wait_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && wait_req && !stop_req) |=> (!cpu_clk_en && per_clk_en));

  // R6
  stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && stop_req) |=> (!cpu_clk_en && !per_clk_en));

  // R3
  stack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_go |=> !stack_go);

  // R3
  stack_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_go |-> cpu_clk_en);

  // R4
  bw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && per_clk_en && brk) |=> (bw_flag && stack_go));

  // R8
  stop_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_clk_en && !bw_flag) |=> !bw_flag);

  // R5
  wdog_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !per_clk_en |-> !wdog_en);
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wait_req  (wait_req),
  .stop_req  (stop_req),
  .brk       (brk),
  .cpu_clk_en(cpu_clk_en),
  .per_clk_en(per_clk_en),
  .stack_go  (stack_go),
  .bw_flag   (bw_flag),
  .wdog_en   (wdog_en)
);

// File: tb/lpm_clk_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_clk_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n, wait_req, stop_req, wake_irq, brk, short_rec, wdog_dis, bw_clr;
  logic cpu_clk_en, per_clk_en, stack_go, bw_flag, wdog_en;
  int   n_cmp = 0;
  int   n_bad = 0;

  always #2.5 clk = ~clk;

  lpm_clk_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .stop_req(stop_req),
    .wake_irq(wake_irq), .brk(brk), .short_rec(short_rec), .wdog_dis(wdog_dis),
    .bw_clr(bw_clr), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .stack_go(stack_go), .bw_flag(bw_flag), .wdog_en(wdog_en)
  );

  // {wait_req, stop_req, wake_irq, brk, bw_clr, cpu, per, stack, bw}
  localparam logic [8:0] VEC [16] = '{
    9'b00000_1100,  // idle in run
    9'b10000_0100,  // enter wait (R2)
    9'b00000_0100,
    9'b01000_0100,  // stop_req ignored in wait (R9)
    9'b00100_1110,  // irq wakes, strobe (R3)
    9'b00000_1100,
    9'b10000_0100,
    9'b00010_1111,  // break wakes, sets flag (R4)
    9'b00000_1101,
    9'b00001_1100,  // clear flag (R4)
    9'b00010_1100,  // break in run ignored (R4)
    9'b10000_0100,
    9'b00011_1111,  // set and clear together: set wins (R4)
    9'b00001_1100,
    9'b11000_0000,  // stop wins over wait (R6)
    9'b10010_0000   // break and wait_req ignored in stop (R8, R9)
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr_in();
    wait_req = 0; stop_req = 0; wake_irq = 0; brk = 0; bw_clr = 0;
  endtask

  // block must be in stop mode on entry
  task automatic run_rec(input int n, input string tag);
    wake_irq = 1;
    step();
    wake_irq = 0;
    chk({tag, " cpu off at start"}, cpu_clk_en, 1'b0);
    chk({tag, " per off at start"}, per_clk_en, 1'b0);
    for (int k = 1; k < n; k++) step();
    chk({tag, " cpu off at last recovery cycle"}, cpu_clk_en, 1'b0);
    chk({tag, " no early strobe"}, stack_go, 1'b0);
    step();
    chk({tag, " cpu back"}, cpu_clk_en, 1'b1);
    chk({tag, " strobe"}, stack_go, 1'b1);
    step();
    chk({tag, " strobe one cycle"}, stack_go, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; short_rec = 1; wdog_dis = 0;
    clr_in();
    repeat (3) @(negedge clk);
    chk("R1 cpu in reset", cpu_clk_en, 1'b1);
    rst_n = 1;
    step();
    chk("R1 cpu", cpu_clk_en, 1'b1);
    chk("R1 per", per_clk_en, 1'b1);
    chk("R1 stack", stack_go, 1'b0);
    chk("R1 bw", bw_flag, 1'b0);

    for (int i = 0; i < 16; i++) begin
      {wait_req, stop_req, wake_irq, brk, bw_clr} = VEC[i][8:4];
      step();
      clr_in();
      chk($sformatf("vec %0d cpu (R2/R3/R6/R9)", i), cpu_clk_en, VEC[i][3]);
      chk($sformatf("vec %0d per (R2/R6)", i), per_clk_en, VEC[i][2]);
      chk($sformatf("vec %0d stack (R3)", i), stack_go, VEC[i][1]);
      chk($sformatf("vec %0d bw (R4/R8)", i), bw_flag, VEC[i][0]);
    end

    // in stop now
    chk("R5 wdog off in stop", wdog_en, 1'b0);
    brk = 1; step(); clr_in();
    chk("R8 break does not wake", per_clk_en, 1'b0);
    run_rec(32, "R7 short");

    // set flag, then a break in stop must leave it set
    wait_req = 1; step(); clr_in();
    brk = 1; step(); clr_in();
    chk("R4 flag set", bw_flag, 1'b1);
    stop_req = 1; step(); clr_in();
    brk = 1; step(); clr_in();
    chk("R8 flag kept in stop", bw_flag, 1'b1);
    chk("R8 still stopped", cpu_clk_en, 1'b0);
    short_rec = 0;
    run_rec(4096, "R7 long");

    // watchdog in wait
    wait_req = 1; step(); clr_in();
    wdog_dis = 0; #1;
    chk("R5 wdog on in wait", wdog_en, 1'b1);
    wdog_dis = 1; #1;
    chk("R5 wdog follows disable", wdog_en, 1'b0);
    wdog_dis = 0;
    wake_irq = 1; step(); clr_in();
    chk("R3 back to run", cpu_clk_en, 1'b1);

    // reset in the middle of recovery
    short_rec = 1;
    stop_req = 1; step(); clr_in();
    wake_irq = 1; step(); clr_in();
    repeat (10) step();
    rst_n = 0; #1;
    chk("R10 async cpu on", cpu_clk_en, 1'b1);
    chk("R10 async per on", per_clk_en, 1'b1);
    chk("R1 flag cleared by reset", bw_flag, 1'b0);
    step();
    rst_n = 1;
    step();
    stop_req = 1; step(); clr_in();
    run_rec(32, "R10 full period after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule